// File: doc/BRIEF.md
# Event-driven integrate-and-fire neuron controller

This block is one spiking neuron that stays asleep until a spike arrives. It has two spike inputs. A rising edge on the excitatory input adds one to a 9-bit signed membrane potential, and a rising edge on the inhibitory input subtracts one. A small wake stage records each edge and raises a clock request toward a shared oscillator. The same condition drops the power-gate enable. Half a cycle later, the wake stage opens a clock ungate to the neuron's state machine. The state machine uses the ungate as its clock enable, so it only advances on rising edges that follow a full low phase of the shared clock. When its work is done, the state machine clears its own wake flops and goes back to sleep.

A parameter selects one of three roles. An input-layer neuron turns every spike straight into a firing request. A hidden-layer neuron integrates, compares against a threshold, and requests a firing slot from an arbiter. It keeps integrating while that request is pending. An output-layer neuron only integrates, and its potential is read for classification. A synchronous frame clear zeroes the potential between frames. The threshold register accepts a new value only while the neuron is asleep.

State machine states:
- `ST_STANDBY`: asleep or just woken.
- `ST_UPDATE`: apply a spike.
- `ST_CHECK`: hidden neuron compares against the threshold.
- `ST_FINISH`: output neuron goes back to sleep.
- `ST_REQ`: firing request pending.
- `ST_UPDATE2`: apply a spike while the request is held.

Transitions:
- STANDBY→UPDATE (hidden or output, spike pending).
- STANDBY→REQ (input, spike pending).
- STANDBY→STANDBY with sleep (woken but nothing pending).
- UPDATE→CHECK (hidden).
- UPDATE→FINISH (output).
- CHECK→REQ (fire).
- CHECK→STANDBY (below threshold).
- FINISH→STANDBY.
- REQ→STANDBY (acknowledge).
- REQ→UPDATE2 (hidden, spike while waiting).
- UPDATE2→REQ.
- UPDATE2→STANDBY (acknowledge).

Top module: `spk_neuron_ctrl`

## Requirements
- R1: A 0→1 change on `spk_pos_i` or `spk_neg_i`, seen at one rising clock edge, sets `clk_req_o` after that edge. A level held high counts as exactly one spike.
- R2: `pwr_gate_o` is 1 (gated) after reset and while asleep. It goes to 0 on the same edge that raises `clk_req_o`, and returns to 1 when the clock request is dropped.
- R3: `clk_ungate_o` rises only on the falling edge that follows the rising edge at which `clk_req_o` rose. It is therefore still 0 when first sampled after `clk_req_o` rises. It falls on the falling edge after `clk_req_o` falls.
- R4: In hidden and output roles, an excitatory spike adds +1 and an inhibitory spike adds −1 to the potential. Both captured together give a net change of 0.
- R5: A hidden neuron whose updated potential is below the threshold returns to standby and drops `clk_req_o` without requesting.
- R6: A hidden neuron whose potential is greater than or equal to the threshold (signed compare) sets the potential to 0 and holds `req_o` high.
- R7: While `req_o` is held, further spikes still change the potential of a hidden neuron, and `req_o` stays high.
- R8: `ack_i` sampled high while `req_o` is high ends the request. `req_o` falls after that edge, and the clock request is dropped unless new spikes are pending.
- R9: In the input role a spike produces a request directly, and the potential stays 0.
- R10: In the output role `req_o` is never asserted, and the potential accumulates spikes on `pot_o`.
- R11: The potential saturates at +255 and −256 instead of wrapping.
- R12: `thr_load_i` writes `thr_val_i` (signed) into the threshold only when the neuron is idle: in standby with clock request and ungate both low. Otherwise the load is ignored. The reset threshold is 4.
- R13: `frame_clr_i` sampled high zeroes the potential at that edge, taking priority over a spike update in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running shared clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spk_pos_i | input | 1 | Excitatory spike input (edge-detected) |
| spk_neg_i | input | 1 | Inhibitory spike input (edge-detected) |
| ack_i | input | 1 | Arbiter grant for the firing request |
| thr_load_i | input | 1 | Threshold write strobe |
| thr_val_i | input | PW | Signed threshold value |
| frame_clr_i | input | 1 | Synchronous potential clear |
| req_o | output | 1 | Firing request to the arbiter |
| clk_req_o | output | 1 | Clock request to the shared oscillator |
| clk_ungate_o | output | 1 | Clock enable for the state machine |
| pwr_gate_o | output | 1 | Power-gate enable, 1 = neuron powered down |
| pot_o | output | PW | Signed membrane potential |

## Verification
The bench runs an input, a hidden and an output neuron side by side, each with a behavioural reference model compared on every clock. The corner cases it targets are these:
- Ungate timing: a design that opened the ungate on the rising edge would let the state machine act one cycle early, and the `clk_ungate_o` comparison would catch it.
- Spikes arriving while a request is pending: an implementation that dropped them, or released the request, would show a wrong potential or an early fall of `req_o`.
- Saturation: a design that wrapped would read −256 after 256 excitatory spikes.
- Threshold loads while busy and frame clears that collide with an update: either mistake changes when the hidden neuron fires or what the output potential reads.
- Simultaneous opposite spikes and long held levels: a design that missed either would add extra counts.

// File: rtl/nrn_pkg.sv
package nrn_pkg;
    typedef enum logic [1:0] {
        MODE_INPUT,
        MODE_HIDDEN,
        MODE_OUTPUT
    } nrn_mode_e;

    typedef enum logic [2:0] {
        ST_STANDBY,
        ST_UPDATE,
        ST_CHECK,
        ST_FINISH,
        ST_REQ,
        ST_UPDATE2
    } nrn_state_e;

    typedef struct packed {
        logic consume;   // clear captured spikes
        logic sleep;     // drop clock request
        logic upd;       // apply spike delta to potential
        logic fire;      // zero potential on firing
    } nrn_ctl_t;
endpackage

// File: rtl/nrn_wake.sv
module nrn_wake (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spk_pos_i,
    input  logic       spk_neg_i,
    input  logic       consume_i,
    input  logic       sleep_i,
    output logic       cap_pos_o,
    output logic       cap_neg_o,
    output logic       clk_req_o,
    output logic       ungate_o
);
    localparam int NCH = 2;

    logic [NCH-1:0] spk, dly, cap, cap_n, rise;
    logic           req_q, req_n;

    assign spk   = {spk_neg_i, spk_pos_i};
    assign rise  = spk & ~dly;
    assign cap_n = rise | (cap & ~{NCH{consume_i}});
    assign req_n = (|cap_n) | (req_q & ~sleep_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dly   <= '0;
            cap   <= '0;
            req_q <= 1'b0;
        end else begin
            dly   <= spk;
            cap   <= cap_n;
            req_q <= req_n;
        end
    end

    // ungate sampled on the falling edge: full low phase before the FSM edge
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) ungate_o <= 1'b0;
        else        ungate_o <= req_q;
    end

    assign cap_pos_o = cap[0];
    assign cap_neg_o = cap[1];
    assign clk_req_o = req_q;

    // R1
    wake_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise) |=> clk_req_o);

    // R3
    ungate_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ungate_o) |-> $rose(clk_req_o));
endmodule

// File: rtl/nrn_fsm.sv
module nrn_fsm
    import nrn_pkg::*;
#(
    parameter nrn_mode_e MODE = MODE_HIDDEN
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       cap_pos_i,
    input  logic       cap_neg_i,
    input  logic       ack_i,
    input  logic       at_thr_i,
    output nrn_ctl_t   ctl_o,
    output logic       req_o,
    output nrn_state_e state_o
);
    nrn_state_e state_q, state_n;
    nrn_ctl_t   ctl;
    logic       any_spk;

    assign any_spk = cap_pos_i | cap_neg_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    state_q <= ST_STANDBY;
        else if (en_i) state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        ctl     = '0;
        req_o   = 1'b0;
        unique case (state_q)
            ST_STANDBY: begin
                if (any_spk) begin
                    if (MODE == MODE_INPUT) begin
                        ctl.consume = 1'b1;
                        state_n     = ST_REQ;
                    end else begin
                        state_n     = ST_UPDATE;
                    end
                end else begin
                    ctl.sleep = 1'b1;
                end
            end
            ST_UPDATE: begin
                ctl.upd     = 1'b1;
                ctl.consume = 1'b1;
                state_n     = (MODE == MODE_OUTPUT) ? ST_FINISH : ST_CHECK;
            end
            ST_CHECK: begin
                if (at_thr_i) begin
                    ctl.fire = 1'b1;
                    state_n  = ST_REQ;
                end else begin
                    ctl.sleep = 1'b1;
                    state_n   = ST_STANDBY;
                end
            end
            ST_FINISH: begin
                ctl.sleep = 1'b1;
                state_n   = ST_STANDBY;
            end
            ST_REQ: begin
                req_o = 1'b1;
                if (ack_i) begin
                    ctl.sleep = 1'b1;
                    state_n   = ST_STANDBY;
                end else if (any_spk) begin
                    if (MODE == MODE_HIDDEN) state_n = ST_UPDATE2;
                    else                     ctl.consume = 1'b1;
                end
            end
            ST_UPDATE2: begin
                req_o       = 1'b1;
                ctl.upd     = 1'b1;
                ctl.consume = 1'b1;
                if (ack_i) begin
                    ctl.sleep = 1'b1;
                    state_n   = ST_STANDBY;
                end else begin
                    state_n   = ST_REQ;
                end
            end
            default: state_n = ST_STANDBY;
        endcase
    end

    assign ctl_o   = en_i ? ctl : '0;
    assign state_o = state_q;

    // R8
    ack_ends_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && ack_i && en_i) |=> !req_o);
endmodule

// File: rtl/nrn_pot.sv
module nrn_pot #(
    parameter int PW       = 9,
    parameter int THR_INIT = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_i,
    input  logic                 upd_i,
    input  logic                 fire_i,
    input  logic                 inc_i,
    input  logic                 dec_i,
    input  logic                 idle_i,
    input  logic                 thr_load_i,
    input  logic signed [PW-1:0] thr_val_i,
    output logic signed [PW-1:0] pot_o,
    output logic                 at_thr_o
);
    localparam int MAXI = (1 << (PW - 1)) - 1;
    localparam int MINI = -(1 << (PW - 1));

    logic signed [PW-1:0] pot_q, pot_n, thr_q;
    logic signed [PW:0]   sum;

    always_comb begin
        sum = {pot_q[PW-1], pot_q};
        if (inc_i && !dec_i)      sum = sum + (PW+1)'(1);
        else if (dec_i && !inc_i) sum = sum - (PW+1)'(1);
        if (int'(sum) > MAXI)      pot_n = PW'(MAXI);
        else if (int'(sum) < MINI) pot_n = PW'(MINI);
        else                       pot_n = sum[PW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pot_q <= '0;
            thr_q <= PW'(THR_INIT);
        end else begin
            if (clr_i || fire_i) pot_q <= '0;
            else if (upd_i)      pot_q <= pot_n;
            if (thr_load_i && idle_i) thr_q <= thr_val_i;
        end
    end

    assign pot_o    = pot_q;
    assign at_thr_o = (pot_q >= thr_q);

    // R11
    sat_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && !clr_i && inc_i && !dec_i && pot_q == PW'(MAXI)) |=> (pot_q == PW'(MAXI)));

    // R12
    thr_busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_load_i && !idle_i) |=> $stable(thr_q));

    // R13
    frame_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (pot_q == '0));

    // R6
    fire_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i |=> (pot_q == '0));
endmodule

// File: rtl/spk_neuron_ctrl.sv
module spk_neuron_ctrl
    import nrn_pkg::*;
#(
    parameter nrn_mode_e MODE     = MODE_HIDDEN,
    parameter int        PW       = 9,
    parameter int        THR_INIT = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 spk_pos_i,
    input  logic                 spk_neg_i,
    input  logic                 ack_i,
    input  logic                 thr_load_i,
    input  logic signed [PW-1:0] thr_val_i,
    input  logic                 frame_clr_i,
    output logic                 req_o,
    output logic                 clk_req_o,
    output logic                 clk_ungate_o,
    output logic                 pwr_gate_o,
    output logic signed [PW-1:0] pot_o
);
    nrn_ctl_t   ctl;
    nrn_state_e state;
    logic       cap_pos, cap_neg, at_thr, idle;

    nrn_wake u_wake (
        .clk       (clk),
        .rst_n     (rst_n),
        .spk_pos_i (spk_pos_i),
        .spk_neg_i (spk_neg_i),
        .consume_i (ctl.consume),
        .sleep_i   (ctl.sleep),
        .cap_pos_o (cap_pos),
        .cap_neg_o (cap_neg),
        .clk_req_o (clk_req_o),
        .ungate_o  (clk_ungate_o)
    );

    nrn_fsm #(.MODE(MODE)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (clk_ungate_o),
        .cap_pos_i (cap_pos),
        .cap_neg_i (cap_neg),
        .ack_i     (ack_i),
        .at_thr_i  (at_thr),
        .ctl_o     (ctl),
        .req_o     (req_o),
        .state_o   (state)
    );

    assign idle = (state == ST_STANDBY) && !clk_req_o && !clk_ungate_o;

    nrn_pot #(.PW(PW), .THR_INIT(THR_INIT)) u_pot (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (frame_clr_i),
        .upd_i      (ctl.upd),
        .fire_i     (ctl.fire),
        .inc_i      (cap_pos),
        .dec_i      (cap_neg),
        .idle_i     (idle),
        .thr_load_i (thr_load_i),
        .thr_val_i  (thr_val_i),
        .pot_o      (pot_o),
        .at_thr_o   (at_thr)
    );

    assign pwr_gate_o = ~clk_req_o;
endmodule

// File: tb/spk_neuron_ctrl_tb_top.sv
module spk_neuron_ctrl_tb_lane #(
    parameter int    LMODE = 1,
    parameter string PTAG  = "R4"
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spk_pos,
    input  logic       spk_neg,
    input  logic       ack,
    input  logic       thr_load,
    input  logic [8:0] thr_val,
    input  logic       frame_clr,
    output logic       req,
    output logic       clk_req,
    output logic       ungate,
    output logic       pgate,
    output logic [8:0] pot,
    output int         n_chk,
    output int         n_err
);
    spk_neuron_ctrl #(.MODE(nrn_pkg::nrn_mode_e'(LMODE))) dut_i (
        .clk(clk), .rst_n(rst_n), .spk_pos_i(spk_pos), .spk_neg_i(spk_neg),
        .ack_i(ack), .thr_load_i(thr_load), .thr_val_i(thr_val),
        .frame_clr_i(frame_clr), .req_o(req), .clk_req_o(clk_req),
        .clk_ungate_o(ungate), .pwr_gate_o(pgate), .pot_o(pot)
    );

    // reference model: 0 standby 1 update 2 check 3 finish 4 req 5 update2
    int m_pd, m_nd, m_cp, m_cn, m_ce, m_ug, m_st, m_pot, m_thr;

    initial begin n_chk = 0; n_err = 0; end

    always @(posedge clk) begin : model
        int cons, slp, upd, fire, st_n, rp, rn, cpn, cnn, any, idle;
        if (!rst_n) begin
            m_pd = 0; m_nd = 0; m_cp = 0; m_cn = 0; m_ce = 0;
            m_st = 0; m_pot = 0; m_thr = 4;
        end else begin
            cons = 0; slp = 0; upd = 0; fire = 0; st_n = m_st;
            any = (m_cp != 0 || m_cn != 0) ? 1 : 0;
            if (m_ug != 0) begin
                if (m_st == 0) begin
                    if (any != 0) begin
                        if (LMODE == 0) begin cons = 1; st_n = 4; end
                        else st_n = 1;
                    end else slp = 1;
                end else if (m_st == 1) begin
                    upd = 1; cons = 1; st_n = (LMODE == 2) ? 3 : 2;
                end else if (m_st == 2) begin
                    if (m_pot >= m_thr) begin fire = 1; st_n = 4; end
                    else begin slp = 1; st_n = 0; end
                end else if (m_st == 3) begin
                    slp = 1; st_n = 0;
                end else if (m_st == 4) begin
                    if (ack) begin slp = 1; st_n = 0; end
                    else if (any != 0) begin
                        if (LMODE == 1) st_n = 5; else cons = 1;
                    end
                end else begin
                    upd = 1; cons = 1;
                    if (ack) begin slp = 1; st_n = 0; end else st_n = 4;
                end
            end
            idle = (m_st == 0 && m_ce == 0 && m_ug == 0) ? 1 : 0;
            if (thr_load && idle != 0) m_thr = int'($signed(thr_val));
            if (frame_clr || fire != 0) m_pot = 0;
            else if (upd != 0) begin
                m_pot = m_pot + m_cp - m_cn;
                if (m_pot > 255) m_pot = 255;
                if (m_pot < -256) m_pot = -256;
            end
            rp = (spk_pos && m_pd == 0) ? 1 : 0;
            rn = (spk_neg && m_nd == 0) ? 1 : 0;
            cpn = (rp != 0 || (m_cp != 0 && cons == 0)) ? 1 : 0;
            cnn = (rn != 0 || (m_cn != 0 && cons == 0)) ? 1 : 0;
            m_ce = (cpn != 0 || cnn != 0 || (m_ce != 0 && slp == 0)) ? 1 : 0;
            m_cp = cpn; m_cn = cnn;
            m_pd = spk_pos ? 1 : 0; m_nd = spk_neg ? 1 : 0;
            m_st = st_n;
        end
    end

    always @(negedge clk or negedge rst_n) begin
        if (!rst_n) m_ug = 0;
        else        m_ug = m_ce;
    end

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s lane%0d %s act=%0d exp=%0d t=%0t", tag, LMODE, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        #3;
        if (rst_n) begin
            cmp(PTAG, "pot", int'($signed(pot)), m_pot);
            cmp("R6", "req", int'(req), (m_st == 4 || m_st == 5) ? 1 : 0);
            cmp("R1", "clk_req", int'(clk_req), m_ce);
            cmp("R2", "pwr_gate", int'(pgate), (m_ce == 0) ? 1 : 0);
            cmp("R3", "ungate", int'(ungate), m_ug);
        end
    end
endmodule

module spk_neuron_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n, spk_pos, spk_neg, thr_load, frame_clr;
    logic ack_i, ack_h, ack_o;
    logic [8:0] thr_val;
    logic auto_i, auto_h;
    int chk, err;

    logic       req_i, req_h, req_o2;
    logic       cr_i, cr_h, cr_o;
    logic       ug_i, ug_h, ug_o;
    logic       pg_i, pg_h, pg_o;
    logic [8:0] pot_i, pot_h, pot_o;
    int c_i, e_i, c_h, e_h, c_o, e_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    spk_neuron_ctrl_tb_lane #(.LMODE(0), .PTAG("R9")) lane_in (
        .clk(clk), .rst_n(rst_n), .spk_pos(spk_pos), .spk_neg(spk_neg), .ack(ack_i),
        .thr_load(thr_load), .thr_val(thr_val), .frame_clr(frame_clr),
        .req(req_i), .clk_req(cr_i), .ungate(ug_i), .pgate(pg_i), .pot(pot_i),
        .n_chk(c_i), .n_err(e_i));
    spk_neuron_ctrl_tb_lane #(.LMODE(1), .PTAG("R4")) lane_hid (
        .clk(clk), .rst_n(rst_n), .spk_pos(spk_pos), .spk_neg(spk_neg), .ack(ack_h),
        .thr_load(thr_load), .thr_val(thr_val), .frame_clr(frame_clr),
        .req(req_h), .clk_req(cr_h), .ungate(ug_h), .pgate(pg_h), .pot(pot_h),
        .n_chk(c_h), .n_err(e_h));
    spk_neuron_ctrl_tb_lane #(.LMODE(2), .PTAG("R10")) lane_out (
        .clk(clk), .rst_n(rst_n), .spk_pos(spk_pos), .spk_neg(spk_neg), .ack(ack_o),
        .thr_load(thr_load), .thr_val(thr_val), .frame_clr(frame_clr),
        .req(req_o2), .clk_req(cr_o), .ungate(ug_o), .pgate(pg_o), .pot(pot_o),
        .n_chk(c_o), .n_err(e_o));

    // arbiter stand-in: grant one cycle after a request is seen
    always @(posedge clk) begin
        #1;
        ack_i = auto_i && req_i;
        ack_h = auto_h && req_h;
        ack_o = req_o2;
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic chk_v(input string tag, input int act, input int exp);
        chk++;
        if (act != exp) begin
            err++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic pulse(input logic p, input logic n);
        spk_pos = p; spk_neg = n;
        step();
        spk_pos = 1'b0; spk_neg = 1'b0;
        repeat (8) step();
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", chk + c_i + c_h + c_o, err + e_i + e_h + e_o);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        chk++; err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        chk = 0; err = 0;
        rst_n = 1'b0; spk_pos = 1'b0; spk_neg = 1'b0; thr_load = 1'b0;
        thr_val = '0; frame_clr = 1'b0; auto_i = 1'b0; auto_h = 1'b0;
        ack_i = 1'b0; ack_h = 1'b0; ack_o = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step(); #2;
        // reset state
        chk_v("R2 reset pwr_gate", int'(pg_h), 1);
        chk_v("R2 reset clk_req", int'(cr_h), 0);
        chk_v("R10 reset pot", int'($signed(pot_o)), 0);
        step();

        // R12: load threshold 2 while idle
        thr_val = 9'd2; thr_load = 1'b1; step(); thr_load = 1'b0; step();

        pulse(1'b1, 1'b0);
        chk_v("R4 hidden +1", int'($signed(pot_h)), 1);
        chk_v("R5 hidden below thr no req", int'(req_h), 0);
        chk_v("R5 hidden asleep", int'(cr_h), 0);
        chk_v("R10 output pot", int'($signed(pot_o)), 1);
        chk_v("R9 input requests", int'(req_i), 1);
        chk_v("R9 input pot stays 0", int'($signed(pot_i)), 0);
        auto_i = 1'b1;

        pulse(1'b1, 1'b0);
        chk_v("R6 hidden fires", int'(req_h), 1);
        chk_v("R6 hidden pot zero", int'($signed(pot_h)), 0);

        pulse(1'b0, 1'b1);
        chk_v("R7 pot updated while pending", int'($signed(pot_h)), -1);
        chk_v("R7 req held", int'(req_h), 1);

        // R12: load attempt while hidden busy must be ignored
        thr_val = 9'd5; thr_load = 1'b1; step(); thr_load = 1'b0;

        auto_h = 1'b1;
        repeat (4) step();
        chk_v("R8 req released", int'(req_h), 0);
        chk_v("R8 clock released", int'(cr_h), 0);
        chk_v("R8 power gated", int'(pg_h), 1);

        repeat (3) pulse(1'b1, 1'b0);
        chk_v("R12 busy load ignored (fired at 2)", int'($signed(pot_h)), 0);

        // R1/R2/R3 wake timing on the output lane; R4 net zero
        spk_pos = 1'b1; spk_neg = 1'b1;
        step();
        spk_pos = 1'b0; spk_neg = 1'b0;
        #2;
        chk_v("R1 clk_req raised", int'(cr_o), 1);
        chk_v("R2 power ungated", int'(pg_o), 0);
        chk_v("R3 ungate still low", int'(ug_o), 0);
        #5;
        chk_v("R3 ungate after falling edge", int'(ug_o), 1);
        repeat (8) step();
        chk_v("R4 both polarities net zero", int'($signed(pot_o)), 4);

        // R1: held level counts once
        spk_pos = 1'b1; repeat (20) step(); spk_pos = 1'b0; repeat (8) step();
        chk_v("R1 held level one spike", int'($signed(pot_o)), 5);

        repeat (260) pulse(1'b1, 1'b0);
        chk_v("R11 saturate high", int'($signed(pot_o)), 255);

        frame_clr = 1'b1; step(); frame_clr = 1'b0; step();
        chk_v("R13 frame clear", int'($signed(pot_o)), 0);

        repeat (260) pulse(1'b0, 1'b1);
        chk_v("R11 saturate low output", int'($signed(pot_o)), -256);
        chk_v("R11 saturate low hidden", int'($signed(pot_h)), -256);

        frame_clr = 1'b1; step(); frame_clr = 1'b0; step();
        repeat (3) pulse(1'b1, 1'b0);
        chk_v("R10 output accumulates", int'($signed(pot_o)), 3);

        // R13: clear coincides with the update edge
        spk_pos = 1'b1; step(); spk_pos = 1'b0; step();
        frame_clr = 1'b1; step(); frame_clr = 1'b0;
        repeat (6) step();
        chk_v("R13 clear beats update", int'($signed(pot_o)), 0);

        repeat (4) step();
        finish_run();
    end
endmodule